// File: doc/BRIEF.md
# Pseudo-random hopping sync clock generator

This block produces a one-bit square wave for the external synchronisation input of a switching regulator. The period of the square wave hops among a small set of discrete values. The hop sequence comes from a maximal-length linear feedback shift register, so the regulator's switching noise is spread over many frequencies rather than piling up at one.

A divider makes a slow step tick, and the register advances once on each tick. The default tick rate is 25 kHz from a 50 MHz clock, which is above the audible band. A combinational decoder uses the low register bits to pick a half-period from a table parameter. A synchronous modulator turns that half-period into an output cycle with exactly 50% duty, and it takes a new value only when an output cycle is complete. An enable input starts and stops the output cleanly.

Top module: `hop_sync_gen`

## Requirements
- R1: The hop register is LFSR_W bits wide (default 7) and is loaded with the non-zero SEED while reset is high. Each step shifts it left by one. The new bit 0 is the XOR of bit 6 and bit 5 (taps at bit positions TAP_HI-1 and TAP_LO-1). The register never holds all zeros.
- R2: The hop register advances exactly once every STEP_DIV clock cycles. The first advance happens on the STEP_DIV-th rising edge after reset is released, and the register holds its value between steps.
- R3: The half-period in use is the table entry HALF_TABLE[i*CNT_W +: CNT_W]. The index i is the value of the low DEC_BITS register bits (default bits 3:0), taken as they were just before the clock edge that starts the output cycle.
- R4: While enabled, each output cycle is high for H clock cycles and then low for H clock cycles, where H is that cycle's half-period.
- R5: A new half-period is taken only at the start of an output cycle. Register steps that fall inside a cycle do not change the length of its high or low phase.
- R6: If enable is low at a clock edge, the output is low after that edge, and the cycle counters are cleared.
- R7: At the first clock edge that samples enable high after it was low, the output goes high. It then stays high for a full half-period, which is looked up as in R3.
- R8: While reset is high, the output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Output enable; low holds the output low |
| sync_out | output | 1 | Spread-spectrum square wave for the regulator sync input |

## Verification
The assertions assume that reset and enable change only between clock edges, and that every table entry is at least 1, so that a half-period of zero cycles cannot occur. The stimulus drives both inputs shortly after the rising edge. It uses a table of sixteen distinct entries from 3 to 18, so that a wrong decode index gives a wrong phase length. The enable windows are random, mixed with a one-cycle enable pulse, a one-cycle disable gap and a reset in the middle of the run. As a result, restarts happen in both the high phase and the low phase.

// File: rtl/hop_sync_pkg.sv
package hop_sync_pkg;
  localparam int DEF_CNT_W = 8;
  localparam int DEF_ENT   = 16;

  // Four half-periods of 10..13 cycles at 50 MHz (2.5 MHz down to about 1.92 MHz),
  // repeated across the sixteen decode slots.
  function automatic logic [DEF_ENT*DEF_CNT_W-1:0] default_halves();
    logic [DEF_ENT*DEF_CNT_W-1:0] t;
    t = '0;
    for (int i = 0; i < DEF_ENT; i++) begin
      t[i*DEF_CNT_W +: DEF_CNT_W] = DEF_CNT_W'(10 + (i % 4));
    end
    return t;
  endfunction
endpackage

// File: rtl/hop_step_tick.sv
module hop_step_tick #(
  parameter int STEP_DIV = 2000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int TW = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [TW-1:0] LAST = TW'(STEP_DIV - 1);

  logic [TW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || tick) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/hop_lfsr.sv
module hop_lfsr #(
  parameter int              W      = 7,
  parameter int              TAP_HI = 7,
  parameter int              TAP_LO = 6,
  parameter logic [W-1:0]    SEED   = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] state
);
  function automatic logic [W-1:0] advance(input logic [W-1:0] s);
    return {s[W-2:0], s[TAP_HI-1] ^ s[TAP_LO-1]};
  endfunction

  always_ff @(posedge clk) begin
    if (rst)       state <= SEED;
    else if (step) state <= advance(state);
  end
endmodule

// File: rtl/hop_decode.sv
module hop_decode #(
  parameter int W        = 7,
  parameter int DEC_BITS = 4,
  parameter int CNT_W    = 8,
  parameter logic [(1<<DEC_BITS)*CNT_W-1:0] HALF_TABLE = '1
) (
  input  logic [W-1:0]     state,
  output logic [CNT_W-1:0] half
);
  localparam int N_ENT = 1 << DEC_BITS;

  function automatic logic [CNT_W-1:0] pick(input logic [DEC_BITS-1:0] idx);
    return HALF_TABLE[int'(idx)*CNT_W +: CNT_W];
  endfunction

  assign half = pick(state[DEC_BITS-1:0]);
endmodule

// File: rtl/hop_modulator.sv
module hop_modulator #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] next_half,
  output logic             wave,
  output logic             load,
  output logic [CNT_W-1:0] cur_half
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  // start from idle, or the low phase has just run out (cycle complete)
  assign load = en && (!run_q || (cnt_zero && !wave));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      wave     <= 1'b0;
      cnt_q    <= '0;
      cur_half <= '0;
    end else if (!en) begin
      run_q <= 1'b0;
      wave  <= 1'b0;
      cnt_q <= '0;
    end else if (load) begin
      run_q    <= 1'b1;
      wave     <= 1'b1;
      cur_half <= next_half;
      cnt_q    <= next_half - 1'b1;
    end else if (cnt_zero) begin
      wave  <= 1'b0;
      cnt_q <= cur_half - 1'b1;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/hop_sync_gen.sv
module hop_sync_gen #(
  parameter int LFSR_W   = 7,
  parameter int TAP_HI   = 7,
  parameter int TAP_LO   = 6,
  parameter logic [LFSR_W-1:0] SEED = 1,
  parameter int STEP_DIV = 2000,
  parameter int DEC_BITS = 4,
  parameter int CNT_W    = hop_sync_pkg::DEF_CNT_W,
  parameter logic [(1<<DEC_BITS)*CNT_W-1:0] HALF_TABLE = hop_sync_pkg::default_halves()
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic sync_out
);
  // named internal events, observed by the bound checker
  logic              step_tick;
  logic [LFSR_W-1:0] lfsr_q;
  logic [CNT_W-1:0]  dec_half;
  logic              mod_load;
  logic [CNT_W-1:0]  cur_half;

  hop_step_tick #(.STEP_DIV(STEP_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(step_tick)
  );

  hop_lfsr #(.W(LFSR_W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst(rst), .step(step_tick), .state(lfsr_q)
  );

  hop_decode #(.W(LFSR_W), .DEC_BITS(DEC_BITS), .CNT_W(CNT_W), .HALF_TABLE(HALF_TABLE)) u_dec (
    .state(lfsr_q), .half(dec_half)
  );

  hop_modulator #(.CNT_W(CNT_W)) u_mod (
    .clk(clk), .rst(rst), .en(en), .next_half(dec_half),
    .wave(sync_out), .load(mod_load), .cur_half(cur_half)
  );
endmodule

// File: rtl/hop_sync_gen_chk.sv
module hop_sync_gen_chk #(
  parameter int LW = 7,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          sync_out,
  input logic          step_tick,
  input logic [LW-1:0] lfsr_q,
  input logic          mod_load,
  input logic [CW-1:0] cur_half
);
  p_lfsr_nonzero_r1: assert property (@(posedge clk) disable iff (rst) lfsr_q != '0);
  p_hold_between_steps_r2: assert property (@(posedge clk) disable iff (rst)
    !step_tick |=> $stable(lfsr_q));
  p_half_only_at_start_r5: assert property (@(posedge clk) disable iff (rst)
    !mod_load |=> $stable(cur_half));
  p_rise_needs_load_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_out) |-> $past(mod_load));
  p_off_is_low_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> !sync_out);
  p_start_high_r7: assert property (@(posedge clk) disable iff (rst)
    mod_load |=> sync_out);
  p_reset_low_r8: assert property (@(posedge clk) rst |=> !sync_out);
endmodule

bind hop_sync_gen hop_sync_gen_chk #(.LW(LFSR_W), .CW(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .sync_out(sync_out), .step_tick(step_tick),
  .lfsr_q(lfsr_q), .mod_load(mod_load), .cur_half(cur_half)
);

// File: tb/hop_sync_gen_bench.sv
module hop_sync_gen_bench;
  localparam int D     = 40;
  localparam int CW    = 8;
  localparam int NENT  = 16;

  function automatic logic [NENT*CW-1:0] bench_table();
    logic [NENT*CW-1:0] t;
    t = '0;
    for (int i = 0; i < NENT; i++) t[i*CW +: CW] = CW'(3 + i);
    return t;
  endfunction
  localparam logic [NENT*CW-1:0] TBL = bench_table();

  function automatic int half_of(input logic [6:0] s);
    return 3 + int'(s[3:0]);
  endfunction
  function automatic logic [6:0] step_of(input logic [6:0] s);
    logic nb;
    nb = s[6] ^ s[5];
    return (s << 1) | 7'(nb);
  endfunction

  logic clk = 1'b0, rst = 1'b1, en = 1'b0;
  logic sync_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hop_sync_gen #(.STEP_DIV(D), .SEED(7'h01), .HALF_TABLE(TBL)) u_hop_sync_gen (
    .clk(clk), .rst(rst), .en(en), .sync_out(sync_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, updated between edges
  logic [6:0] cur_s, prev_s;
  int  edges = 0;
  logic rst_p = 1'b1, en_p = 1'b0, en_pp = 1'b0, out_l = 1'b0;
  int  exp_h = 0, len = 0;
  bit  valid = 1'b0, in_low = 1'b0;

  always @(negedge clk) begin
    if (rst_p) begin
      cur_s = 7'h01; prev_s = 7'h01; edges = 0; valid = 0;
      check(sync_out == 1'b0, "R8", int'(sync_out), 0);
    end else begin
      edges++;
      prev_s = cur_s;
      if (edges % D == 0) cur_s = step_of(cur_s);
      if (!en_p) begin
        check(sync_out == 1'b0, "R6", int'(sync_out), 0);
        valid = 0;
      end else begin
        if (!en_pp) check(sync_out == 1'b1, "R7", int'(sync_out), 1);
        if (sync_out && !out_l) begin
          if (valid && in_low) check(len == exp_h, "R4 R5 low phase", len, exp_h);
          exp_h = half_of(prev_s); len = 1; valid = 1; in_low = 0;
        end else if (!sync_out && out_l) begin
          if (valid) check(len == exp_h, "R1 R2 R3 high phase", len, exp_h);
          len = 1; in_low = 1;
        end else begin
          len++;
        end
      end
    end
    out_l = sync_out; en_pp = rst_p ? 1'b0 : en_p; en_p = en; rst_p = rst;
  end

  task automatic drive(input logic r, input logic e, input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #2; rst = r; en = e;
    end
  endtask

  initial begin
    void'($urandom(1234));
    drive(1, 0, 4);
    drive(0, 0, 3);
    drive(0, 1, 1);     // one-cycle enable pulse
    drive(0, 0, 5);
    drive(0, 1, 300);
    drive(0, 0, 1);     // one-cycle gap
    drive(0, 1, 400);
    for (int s = 0; s < 40; s++) begin
      drive(0, ($urandom % 4) != 0, 1 + ($urandom % 150));
    end
    drive(1, 0, 3);     // mid-run reset
    drive(0, 1, 2000);  // long run: many register steps and hops
    drive(0, 0, 3);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule